// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target (2K x 8)

This block acts as the target end of a two-wire serial bus and behaves like a 2048-byte serial EEPROM. A fast system clock samples the bus clock and data lines through synchronizers. The block never drives the data line high. It only asserts an open-drain pull-down enable, and board logic turns that enable into a low level on the wire.

A controller opens every command with a start condition and closes it with a stop condition. The first byte carries a four-bit type code, three page bits and a direction bit. The page bits supply the top three bits of the eleven-bit memory address, so the target answers for all eight page values.

A write command carries a word address followed by any number of data bytes, and each byte is stored at a running address. A random read is a write that carries only the word address, followed by a repeated start and a read command. A read streams bytes from the running address for as long as the controller acknowledges them. The storage is an internal register array, and a protect input blocks writes to it.

Top module: `i2c_eeprom_target`

## Requirements
- R1: SDA falling while SCL is high is a start condition in every state. It abandons any byte in progress without storing it, and the next eight bits are taken as a new address byte.
- R2: SDA rising while SCL is high is a stop condition. It returns the block to idle, and bytes clocked after it get no acknowledge until a new start.
- R3: The target acknowledges an address byte only if its bits 7..4 equal 4'b1010, by pulling SDA low for the ninth clock. Otherwise it sends no acknowledge and ignores the bus until the next start.
- R4: Address-byte bits 3..1 become bits 10..8 of the memory address that the next word-address byte loads. Every value of these bits is accepted.
- R5: Address-byte bit 0 gives the direction. A 0 selects write, where the word address and data are received. A 1 selects read, and the target acknowledges the address byte before it sends data.
- R6: In a write, the target acknowledges the word-address byte and every data byte. Each data byte is stored at the current address, and the address then increments, wrapping from 0x7FF to 0x000.
- R7: While wpIn is 1, data bytes are still acknowledged but memory does not change.
- R8: A read starts at the current address, which the last word address or the last access left there. Bits 3..1 of a read address byte do not change it. Bytes go out MSB first.
- R9: A low acknowledge from the controller after a read byte makes the target send the byte at the next address, which wraps from 0x7FF to 0x000.
- R10: A high acknowledge (NACK) after a read byte ends the transfer. SDA stays released on every later clock until a start or stop.
- R11: sdaOe changes only while SCL is low, a few system clocks after SCL falls.
- R12: After reset, sdaOe is 0, the current address is 0x000 and every memory byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus bit rate |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock level as seen on the wire |
| sdaIn | input | 1 | Bus data level as seen on the wire |
| wpIn | input | 1 | Write protect; 1 blocks memory updates |
| sdaOe | output | 1 | Open-drain enable; 1 pulls SDA low |

## Verification
The bench sends a byte after a stop and another after a bad type code, and expects no acknowledge for either. A target that left its idle state too early would answer these bytes. It then cuts a data byte in half with a repeated start and reads that location back as zero. A design that stored the partial byte would return garbage there, and one that missed the start would fail to acknowledge the new read. Writes and reads that cross 0x7FF must land at 0x000; a counter that saturated or carried into the page bits would read back the wrong byte. After a NACK, one more byte must read as all ones, which shows that a target which kept shifting data has been caught.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADR,
    ST_WDAT,
    ST_RDAT,
    ST_MACK,
    ST_ACK,
    ST_IGNORE
  } ctlState_e;

  // Strobes issued by the controller to the datapath, one cycle wide.
  typedef struct packed {
    logic shiftEn;  // shift the sampled SDA into the receive register
    logic pageLd;   // capture page bits of the address byte
    logic addrLd;   // load the current address from page bits and word byte
    logic memWr;    // store the received byte at the current address
    logic addrInc;  // advance the current address
    logic txLd;     // load a read byte and present its MSB
    logic txNext;   // present the next bit of the read byte
    logic oeAck;    // pull SDA low for an acknowledge
    logic oeRel;    // release SDA
  } dpStrobe_t;

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CLKS   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic startDet,
  output logic stopDet,
  output logic drvTick
);

  logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
  logic                   sclPrev, sdaPrev;
  logic [HOLD_CLKS-1:0]   tickPipe;
  logic                   sclFall;

  assign sclS     = sclPipe[SYNC_STAGES-1];
  assign sdaS     = sdaPipe[SYNC_STAGES-1];
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;
  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign drvTick  = tickPipe[HOLD_CLKS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe  <= '1;
      sdaPipe  <= '1;
      sclPrev  <= 1'b1;
      sdaPrev  <= 1'b1;
      tickPipe <= '0;
    end else begin
      sclPipe  <= {sclPipe[SYNC_STAGES-2:0], sclIn};
      sdaPipe  <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
      sclPrev  <= sclS;
      sdaPrev  <= sdaS;
      tickPipe <= {tickPipe[HOLD_CLKS-2:0], sclFall};
    end
  end

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eeprom_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sclRise,
  input  logic       drvTick,
  input  logic       sdaS,
  input  logic       devMatch,
  input  logic       rxRead,
  output dpStrobe_t  stb
);

  ctlState_e stQ, stD, nxQ, nxD;
  logic [2:0] cntQ, cntD;
  logic       riseQ, riseD;  // ninth clock has risen in an acknowledge phase

  always_comb begin
    stb   = '0;
    stD   = stQ;
    nxD   = nxQ;
    cntD  = cntQ;
    riseD = riseQ;
    if (startDet) begin
      stD = ST_DEV;
      cntD = '0;
      riseD = 1'b0;
      stb.oeRel = 1'b1;
    end else if (stopDet) begin
      stD = ST_IDLE;
      cntD = '0;
      riseD = 1'b0;
      stb.oeRel = 1'b1;
    end else begin
      case (stQ)
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (sclRise) begin
            stb.shiftEn = 1'b1;
            if (cntQ == 3'd7) begin
              cntD  = '0;
              riseD = 1'b0;
              stD   = ST_ACK;
              if (stQ == ST_DEV) begin
                if (devMatch) begin
                  stb.pageLd = 1'b1;
                  nxD = rxRead ? ST_RDAT : ST_WADR;
                end else begin
                  stD = ST_IGNORE;
                end
              end else if (stQ == ST_WADR) begin
                stb.addrLd = 1'b1;
                nxD = ST_WDAT;
              end else begin
                stb.memWr   = 1'b1;
                stb.addrInc = 1'b1;
                nxD = ST_WDAT;
              end
            end else begin
              cntD = cntQ + 3'd1;
            end
          end
        end
        ST_ACK: begin
          if (sclRise) begin
            riseD = 1'b1;
          end else if (drvTick) begin
            if (!riseQ) begin
              stb.oeAck = 1'b1;
            end else begin
              riseD = 1'b0;
              cntD  = '0;
              stD   = nxQ;
              if (nxQ == ST_RDAT) stb.txLd  = 1'b1;
              else                stb.oeRel = 1'b1;
            end
          end
        end
        ST_RDAT: begin
          if (sclRise) begin
            if (cntQ == 3'd7) begin
              cntD  = '0;
              riseD = 1'b0;
              stb.addrInc = 1'b1;
              stD = ST_MACK;
            end else begin
              cntD = cntQ + 3'd1;
            end
          end else if (drvTick) begin
            stb.txNext = 1'b1;
          end
        end
        ST_MACK: begin
          if (sclRise) begin
            if (sdaS) stD = ST_IGNORE;
            else      riseD = 1'b1;
          end else if (drvTick) begin
            if (!riseQ) begin
              stb.oeRel = 1'b1;
            end else begin
              riseD = 1'b0;
              stb.txLd = 1'b1;
              stD = ST_RDAT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ   <= ST_IDLE;
      nxQ   <= ST_IDLE;
      cntQ  <= '0;
      riseQ <= 1'b0;
    end else begin
      stQ   <= stD;
      nxQ   <= nxD;
      cntQ  <= cntD;
      riseQ <= riseD;
    end
  end

  // R1: a start always restarts address reception at bit zero
  p_start_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> (stQ == ST_DEV && cntQ == 3'd0));

  // R2: a stop returns to idle
  p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stopDet && !startDet) |=> stQ == ST_IDLE);

  // R10: controller NACK ends the read
  p_nack_ends_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stQ == ST_MACK && sclRise && sdaS && !startDet && !stopDet) |=> stQ == ST_IGNORE);

endmodule

// File: rtl/eeprom_dp.sv
module eeprom_dp
  import eeprom_pkg::*;
#(
  parameter int       ADDR_W   = 11,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t ctl,
  input  logic      sdaS,
  input  logic      wpIn,
  output logic      devMatch,
  output logic      rxRead,
  output logic      sdaOe
);

  localparam int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - DATA_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] shiftQ, rxByte, txQ, memRd;
  logic [PAGE_W-1:0] pageQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] memQ [DEPTH];

  assign rxByte   = {shiftQ[DATA_W-2:0], sdaS};
  assign devMatch = (rxByte[DATA_W-1:DATA_W-4] == DEV_CODE);
  assign rxRead   = rxByte[0];
  assign memRd    = memQ[addrQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
      pageQ  <= '0;
      addrQ  <= '0;
      txQ    <= '0;
      sdaOe  <= 1'b0;
    end else begin
      if (ctl.shiftEn) shiftQ <= rxByte;
      if (ctl.pageLd)  pageQ  <= rxByte[PAGE_W:1];
      if (ctl.addrLd)       addrQ <= {pageQ, rxByte};
      else if (ctl.addrInc) addrQ <= addrQ + 1'b1;
      if (ctl.txLd)        txQ <= memRd;
      else if (ctl.txNext) txQ <= {txQ[DATA_W-2:0], 1'b0};
      if (ctl.oeRel)       sdaOe <= 1'b0;
      else if (ctl.oeAck)  sdaOe <= 1'b1;
      else if (ctl.txLd)   sdaOe <= ~memRd[DATA_W-1];
      else if (ctl.txNext) sdaOe <= ~txQ[DATA_W-2];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) memQ[i] <= '0;
    end else if (ctl.memWr && !wpIn) begin
      memQ[addrQ] <= rxByte;
    end
  end

  // R7: a protected write leaves the addressed byte unchanged
  p_wp_keeps_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.memWr && wpIn) |=> memQ[$past(addrQ)] == $past(memRd));

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
  import eeprom_pkg::*;
#(
  parameter int         ADDR_W      = 11,
  parameter logic [3:0] DEV_CODE    = 4'b1010,
  parameter int         SYNC_STAGES = 2,
  parameter int         HOLD_CLKS   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic wpIn,
  output logic sdaOe
);

  logic      sclS, sdaS, sclRise, startDet, stopDet, drvTick;
  logic      devMatch, rxRead;
  dpStrobe_t stb;

  eeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise),
    .startDet(startDet), .stopDet(stopDet), .drvTick(drvTick)
  );

  eeprom_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startDet(startDet), .stopDet(stopDet),
    .sclRise(sclRise), .drvTick(drvTick), .sdaS(sdaS),
    .devMatch(devMatch), .rxRead(rxRead), .stb(stb)
  );

  eeprom_dp #(.ADDR_W(ADDR_W), .DEV_CODE(DEV_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(stb), .sdaS(sdaS), .wpIn(wpIn),
    .devMatch(devMatch), .rxRead(rxRead), .sdaOe(sdaOe)
  );

  // R11: the pull-down enable moves only while the clock is low
  p_oe_scl_low_r11: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclS);

endmodule

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;

  localparam int HP = 20;  // system clocks per half bus period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSdaLow = 1'b0;
  logic wpIn = 1'b0;
  logic sdaOe;
  logic sdaBus;

  int errors = 0;
  int checks = 0;
  int r11Bad = 0;
  logic oePrev = 1'b0;

  assign sdaBus = !(mSdaLow || sdaOe);

  always #10 clk = ~clk;  // 50 MHz

  i2c_eeprom_target u0 (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .wpIn(wpIn), .sdaOe(sdaOe)
  );

  // R11 monitor: any enable change seen while the clock line is high
  always @(negedge clk) begin
    if (rstN && (sdaOe !== oePrev) && mScl) r11Bad++;
    oePrev = sdaOe;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic busStart();  // also used as a repeated start
    mSdaLow = 1'b0; tick(HP);
    mScl = 1'b1;    tick(HP);
    mSdaLow = 1'b1; tick(HP);
    mScl = 1'b0;
  endtask

  task automatic busStop();
    mSdaLow = 1'b1; tick(HP);
    mScl = 1'b1;    tick(HP);
    mSdaLow = 1'b0; tick(HP);
  endtask

  task automatic sendBits(logic [7:0] b, int n);
    for (int i = 0; i < n; i++) begin
      mSdaLow = !b[7-i]; tick(HP);
      mScl = 1'b1;       tick(HP);
      mScl = 1'b0;
    end
  endtask

  task automatic sendByte(logic [7:0] b, output logic ack);
    sendBits(b, 8);
    mSdaLow = 1'b0; tick(HP);
    mScl = 1'b1;    tick(HP/2);
    ack = !sdaBus;  tick(HP/2);
    mScl = 1'b0;
  endtask

  task automatic recvByte(logic ackLow, output logic [7:0] b);
    mSdaLow = 1'b0;
    for (int i = 0; i < 8; i++) begin
      tick(HP);
      mScl = 1'b1; tick(HP/2);
      b[7-i] = sdaBus; tick(HP/2);
      mScl = 1'b0;
    end
    mSdaLow = ackLow; tick(HP);
    mScl = 1'b1;      tick(HP);
    mScl = 1'b0;
  endtask

  task automatic setAddr(logic [7:0] dev, logic [7:0] word);
    logic a;
    busStart();
    sendByte(dev, a);
    sendByte(word, a);
  endtask

  task automatic tResetRead();
    logic a; logic [7:0] d;
    chk("R12 sdaOe after reset", sdaOe, 0);
    busStart();
    sendByte(8'hA1, a); chk("R5 read address ack", a, 1);
    recvByte(1'b0, d);  chk("R12 byte at 0x000 after reset", d, 8'h00);
    busStop();
  endtask

  task automatic tMismatch();
    logic a;
    busStart();
    sendByte(8'hB0, a); chk("R3 wrong type code not acked", a, 0);
    sendByte(8'hA0, a); chk("R3 ignored until next start", a, 0);
    busStop();
    sendByte(8'hA0, a); chk("R2 no ack after stop", a, 0);
    busStop();
  endtask

  task automatic tPageWrite();
    logic a; logic [7:0] d;
    busStart();
    sendByte(8'hAA, a); chk("R4 page 5 address acked", a, 1);
    sendByte(8'h3C, a); chk("R6 word address acked", a, 1);
    sendByte(8'h11, a); chk("R6 data byte 0 acked", a, 1);
    sendByte(8'h22, a); chk("R6 data byte 1 acked", a, 1);
    busStop();
    setAddr(8'hAA, 8'h3C);
    busStart();
    sendByte(8'hA1, a); chk("R8 read after repeated start acked", a, 1);
    recvByte(1'b1, d);  chk("R8 random read 0x53C", d, 8'h11);
    recvByte(1'b0, d);  chk("R9 sequential read 0x53D", d, 8'h22);
    recvByte(1'b0, d);  chk("R10 released after NACK", d, 8'hFF);
    busStop();
    setAddr(8'hA0, 8'h3C);
    busStart();
    sendByte(8'hA1, a);
    recvByte(1'b0, d);  chk("R4 page 0 location untouched", d, 8'h00);
    busStop();
  endtask

  task automatic tWrap();
    logic a; logic [7:0] d;
    setAddr(8'hAE, 8'hFF);
    sendByte(8'h5A, a);
    sendByte(8'hA5, a);
    busStop();
    setAddr(8'hA0, 8'h00);
    busStart();
    sendByte(8'hA1, a);
    recvByte(1'b0, d);  chk("R6 write wrapped to 0x000", d, 8'hA5);
    busStop();
    setAddr(8'hAE, 8'hFF);
    busStart();
    sendByte(8'hA1, a);
    recvByte(1'b1, d);  chk("R6 byte at 0x7FF", d, 8'h5A);
    recvByte(1'b0, d);  chk("R9 read wrapped to 0x000", d, 8'hA5);
    busStop();
  endtask

  task automatic tProtect();
    logic a; logic [7:0] d;
    wpIn = 1'b1;
    busStart();
    sendByte(8'hA4, a);
    sendByte(8'h10, a); chk("R7 word address acked under protect", a, 1);
    sendByte(8'h77, a); chk("R7 data acked under protect", a, 1);
    busStop();
    wpIn = 1'b0;
    setAddr(8'hA4, 8'h10);
    busStart();
    sendByte(8'hA1, a);
    recvByte(1'b0, d);  chk("R7 protected byte unchanged", d, 8'h00);
    busStop();
  endtask

  task automatic tAbort();
    logic a; logic [7:0] d;
    setAddr(8'hA4, 8'h20);
    sendBits(8'h99, 4);
    busStart();
    sendByte(8'hA5, a); chk("R1 address acked after mid-byte start", a, 1);
    recvByte(1'b0, d);  chk("R1 partial byte not stored", d, 8'h00);
    busStop();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    tick(5);
    rstN = 1'b1;
    tick(5);
    tResetRead();
    tMismatch();
    tPageWrite();
    tWrap();
    tProtect();
    tAbort();
    tick(HP);
    chk("R11 enable changed only with SCL low", r11Bad, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule